// File: doc/BRIEF.md
# Gated Serial Byte Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Software or upstream logic pushes bytes into a four-entry queue. A shared bit-rate strobe, `bitTick`, sets the pace. Each pulse of the strobe marks one bit boundary on the line.

A transmit-enable bit gives software flow control. While the bit is set, queued bytes leave back to back, with no idle gap between frames. Clearing the bit never cuts a frame short. The frame already on the line runs through its stop bit, then the line stays idle while bytes wait in the queue. Setting the bit again resumes transmission with no further action. The same control write also loads a receive-enable bit. That bit is brought out as a level that a separate receiver uses to switch its logic on or off.

Top module: `uart_tx_gated`

## Requirements
- R1: When no frame is in progress, including straight after reset, `txd` is 1 and `busy` is 0.
- R2: Each frame is `txd`=0 for the start bit, then the eight data bits with bit 0 first, then `txd`=1 for the stop bit. Every bit lasts exactly the number of clock cycles between two `bitTick` pulses.
- R3: While the enable is set and the queue holds data, the start bit of the next frame follows the end of the stop bit directly. Consecutive start bits are therefore ten tick periods apart.
- R4: If the transmit enable is cleared during a frame, that frame still completes with correct data and its stop bit.
- R5: While the transmit enable is 0 and the line is idle, no frame starts and queued bytes are kept. Once the enable is set to 1, those bytes are sent in order.
- R6: After reset, `txEnable` and `rxEnable` both read 1.
- R7: A pulse on `ctrlWrite` loads `ctrlTxEn` into `txEnable` and `ctrlRxEn` into `rxEnable` together, and `rxEnable` has no effect on transmission.
- R8: The queue holds 4 bytes and sends them in the order they were pushed. `fifoFull` is 1 exactly when 4 bytes are held.
- R9: A push while `fifoFull` is 1 is discarded and sets `overflow`. `overflow` then stays 1 until reset.
- R10: `busy` is 1 from the first cycle of the start bit to the last cycle of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse marking each bit boundary |
| ctrlWrite | input | 1 | Loads both enable bits |
| ctrlTxEn | input | 1 | Transmit enable value to load |
| ctrlRxEn | input | 1 | Receive enable value to load |
| pushValid | input | 1 | Push `pushData` into the queue |
| pushData | input | 8 | Byte to queue |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |
| fifoFull | output | 1 | Queue holds 4 bytes |
| overflow | output | 1 | Sticky flag for a dropped push |
| txEnable | output | 1 | Current transmit enable |
| rxEnable | output | 1 | Current receive enable, gates receiver logic |

## Verification
A corrupted bit counter or shift register shows up at the port within one frame: the bench sees a shifted byte, a stop bit that is missing or too short, or a bit held too long. A sequencer that ignores the enable, or a queue pointer that slips, shows up at the next frame boundary. The symptoms are a frame sent while disabled, a lost or duplicated byte, or a gap between back-to-back frames. Because every decoded byte is compared against the order of the pushes, each of these faults is caught within a few tick periods of the frame where it occurs.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Strobes the sequencer hands to the datapath, at most one per cycle
  typedef struct packed {
    logic loadStart;  // take the queue head, drive the start bit
    logic shiftOut;   // drive the next data bit
    logic sendStop;   // drive the stop bit
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txState_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReq,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             pushOk, popOk;

  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign pushOk   = pushValid && !full;
  assign popOk    = popReq && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pushValid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobe_t            strobe,
  input  logic [DATA_BITS-1:0] loadData,
  output logic                 txd
);
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      txd      <= 1'b1;
    end else if (strobe.loadStart) begin
      shiftReg <= loadData;
      txd      <= 1'b0;
    end else if (strobe.shiftOut) begin
      shiftReg <= {1'b0, shiftReg[DATA_BITS-1:1]};
      txd      <= shiftReg[0];
    end else if (strobe.sendStop) begin
      txd      <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      txEnable,
  input  logic      fifoEmpty,
  output txStrobe_t strobe,
  output logic      popReq,
  output logic      busy
);
  localparam int CNTW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DATA_BITS - 1);

  txState_t        state, stateNext;
  logic [CNTW-1:0] bitCnt;
  logic            startOk;

  assign startOk = txEnable && !fifoEmpty;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (bitTick) begin
      unique case (state)
        ST_IDLE: if (startOk) begin
          strobe.loadStart = 1'b1;
          stateNext        = ST_START;
        end
        ST_START: begin
          strobe.shiftOut = 1'b1;
          stateNext       = ST_DATA;
        end
        ST_DATA: begin
          if (bitCnt == LAST_BIT) begin
            strobe.sendStop = 1'b1;
            stateNext       = ST_STOP;
          end else begin
            strobe.shiftOut = 1'b1;
          end
        end
        ST_STOP: begin
          // frame boundary: the line is free, decide on the next frame
          if (startOk) begin
            strobe.loadStart = 1'b1;
            stateNext        = ST_START;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign popReq = strobe.loadStart;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.loadStart)
        bitCnt <= '0;
      else if (strobe.shiftOut && state == ST_DATA)
        bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 ctrlWrite,
  input  logic                 ctrlTxEn,
  input  logic                 ctrlRxEn,
  input  logic                 pushValid,
  input  logic [DATA_BITS-1:0] pushData,
  output logic                 txd,
  output logic                 busy,
  output logic                 fifoFull,
  output logic                 overflow,
  output logic                 txEnable,
  output logic                 rxEnable
);
  txStrobe_t            strobe;
  logic                 popReq, fifoEmpty;
  logic [DATA_BITS-1:0] headData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnable <= 1'b1;
      rxEnable <= 1'b1;
    end else if (ctrlWrite) begin
      txEnable <= ctrlTxEn;
      rxEnable <= ctrlRxEn;
    end
  end

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_BITS)) u_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .headData(headData), .empty(fifoEmpty),
    .full(fifoFull), .overflow(overflow)
  );

  uart_tx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .fifoEmpty(fifoEmpty), .strobe(strobe), .popReq(popReq), .busy(busy)
  );

  uart_tx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(headData), .txd(txd)
  );
endmodule

// File: rtl/uart_tx_gated_chk.sv
module uart_tx_gated_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic pushValid,
  input logic txd,
  input logic busy,
  input logic fifoFull,
  input logic overflow,
  input logic txEnable
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);  // R1

  AST_LINE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txd));  // R2

  AST_NO_START_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !txEnable) |=> !busy);  // R5

  AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && fifoFull) |=> overflow);  // R9

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);  // R9

  AST_BUSY_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> txd);  // R10
endmodule

bind uart_tx_gated uart_tx_gated_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .pushValid(pushValid),
  .txd(txd), .busy(busy), .fifoFull(fifoFull), .overflow(overflow),
  .txEnable(txEnable)
);

// File: tb/sim_uart_tx_gated.sv
`timescale 1ns/1ps
module sim_uart_tx_gated;
  localparam int TICK  = 4;
  localparam int FRAME = 10 * TICK;

  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b0;
  logic ctrlWrite = 1'b0, ctrlTxEn = 1'b0, ctrlRxEn = 1'b0;
  logic pushValid = 1'b0;
  logic [7:0] pushData = '0;
  logic txd, busy, fifoFull, overflow, txEnable, rxEnable;

  int     testsRun = 0, testsFailed = 0, framesSeen = 0;
  longint cyc = 0, lastStart = 0;
  bit     b2bCheck = 0, havePrev = 0, done = 0;
  logic [7:0] expQ[$];

  uart_tx_gated u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ctrlWrite(ctrlWrite),
    .ctrlTxEn(ctrlTxEn), .ctrlRxEn(ctrlRxEn), .pushValid(pushValid),
    .pushData(pushData), .txd(txd), .busy(busy), .fifoFull(fifoFull),
    .overflow(overflow), .txEnable(txEnable), .rxEnable(rxEnable)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (TICK - 1) @(negedge clk);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic tx, input logic rx);
    @(negedge clk);
    ctrlWrite = 1'b1; ctrlTxEn = tx; ctrlRxEn = rx;
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic pushRaw(input logic [7:0] d);
    @(negedge clk);
    pushValid = 1'b1; pushData = d;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] d);
    @(negedge clk);
    while (fifoFull) @(negedge clk);
    pushValid = 1'b1; pushData = d;
    expQ.push_back(d);
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic waitDrain();
    @(negedge clk);
    while (expQ.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // line monitor: decodes every frame and compares it against the pushes
  initial begin
    logic [9:0] bits;
    logic [7:0] e;
    bit stable, busyOk;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (txd == 1'b0) begin
        if (b2bCheck && havePrev)
          check(cyc - lastStart == FRAME, "R3", "start spacing", cyc - lastStart, FRAME);
        lastStart = cyc;
        havePrev  = b2bCheck;
        stable = 1; busyOk = 1;
        for (int b = 0; b < 10; b++) begin
          for (int s = 0; s < TICK; s++) begin
            if (!(b == 0 && s == 0)) @(negedge clk);
            if (s == 0) bits[b] = txd;
            else if (txd != bits[b]) stable = 0;
            if (!busy) busyOk = 0;
          end
        end
        check(stable, "R2", "bit held one tick period", stable, 1);
        check(bits[0] == 1'b0 && bits[9] == 1'b1, "R2", "start/stop levels",
              {bits[9], bits[0]}, 2);
        check(busyOk, "R10", "busy across frame", busyOk, 1);
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected frame", bits[8:1], 0);
        end else begin
          e = expQ.pop_front();
          check(bits[8:1] == e, "R2", "data byte LSB first", bits[8:1], e);
        end
        framesSeen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int f0, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1", "idle after reset", {txd, busy}, 2);
    check(txEnable && rxEnable, "R6", "enables after reset", {txEnable, rxEnable}, 3);
    check(!overflow && !fifoFull, "R9", "flags after reset", {overflow, fifoFull}, 0);

    // sweep every byte value, queue kept fed: back-to-back frames
    b2bCheck = 1; havePrev = 0;
    for (int v = 0; v < 256; v++) pushByte(8'(v));
    waitDrain();
    b2bCheck = 0;
    check(framesSeen == 256, "R8", "frames in sweep", framesSeen, 256);
    check(txd == 1'b1 && !busy, "R1", "idle after sweep", {txd, busy}, 2);

    // enable cleared in the middle of a frame
    f0 = framesSeen;
    pushByte(8'hA5);
    pushByte(8'h3C);
    while (!busy) @(negedge clk);
    repeat (15) @(negedge clk);
    writeCtrl(1'b0, 1'b1);
    check(txEnable == 1'b0, "R7", "tx enable loaded 0", txEnable, 0);
    while (busy) @(negedge clk);
    check(framesSeen == f0 + 1, "R4", "frame completed after disable", framesSeen, f0 + 1);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy || !txd) bad++;
    end
    check(bad == 0, "R5", "no frame while disabled", bad, 0);
    check(expQ.size() == 1, "R5", "byte kept queued", expQ.size(), 1);
    writeCtrl(1'b1, 1'b1);
    waitDrain();
    check(framesSeen == f0 + 2, "R5", "resume after enable", framesSeen, f0 + 2);

    // queue depth and overflow while disabled
    f0 = framesSeen;
    writeCtrl(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) pushByte(8'h10 + 8'(i));
    @(negedge clk);
    check(fifoFull == 1'b1, "R8", "full at 4 entries", fifoFull, 1);
    check(overflow == 1'b0, "R9", "no overflow yet", overflow, 0);
    pushRaw(8'hEE);
    check(overflow == 1'b1, "R9", "overflow on full push", overflow, 1);
    writeCtrl(1'b1, 1'b1);
    waitDrain();
    check(framesSeen == f0 + 4, "R9", "dropped byte not sent", framesSeen, f0 + 4);
    check(overflow == 1'b1, "R9", "overflow sticky", overflow, 1);
    check(fifoFull == 1'b0, "R8", "not full after drain", fifoFull, 0);

    // receive enable is independent of transmission
    writeCtrl(1'b1, 1'b0);
    check(rxEnable == 1'b0 && txEnable == 1'b1, "R7", "rx off tx on",
          {txEnable, rxEnable}, 2);
    f0 = framesSeen;
    pushByte(8'h81);
    waitDrain();
    check(framesSeen == f0 + 1, "R7", "tx runs with rx off", framesSeen, f0 + 1);
    writeCtrl(1'b0, 1'b1);
    check(rxEnable == 1'b1 && txEnable == 1'b0, "R7", "rx on tx off",
          {txEnable, rxEnable}, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule